// File: doc/BRIEF.md
# Oscillator Fault Flag Controller

This block watches the fault signals of two crystal oscillators and turns them into sticky fault flags that software clears. The first oscillator runs in either a low-frequency or a high-frequency mode, and only the fault signal of the selected mode counts for it. Each oscillator has its own flag. A summary flag combines them. When the summary flag and an interrupt enable bit are both set, the block raises a non-maskable interrupt request.

Software clears each flag with a strobe. A clear has no effect while the flag's fault condition is still present. While a fault exists, the block drives a fallback indication so that the clock multiplexers outside the block select a safe internal source. The fallback ends only when software clears the summary flag at a moment when no fault condition and no oscillator flag remain. The user's clock selection then applies again.

Top module: `osc_fault_ctrl`

## Requirements
- R1: While the active-low power-up reset `rst_n` is low, every output is 0: both oscillator flags, the summary flag, the interrupt enable, the interrupt request and the fallback indication.
- R2: Each raw fault input passes through a two-flop synchroniser. A raw fault that goes high before a rising edge shows on its flag after the third rising edge, and not after the second.
- R3: The fault condition of oscillator 1 follows `osc1_hf_fault_raw` when `osc1_hf_sel` is 1 and `osc1_lf_fault_raw` when it is 0. A fault on the mode that is not selected leaves `osc1_flag` at 0.
- R4: Once set, an oscillator flag stays at 1 after its fault condition goes away, until software clears it.
- R5: A clear strobe for an oscillator flag has no effect while that oscillator's fault condition is present. When a set and a clear fall on the same edge, the set wins.
- R6: A clear strobe for an oscillator flag whose fault condition is absent takes the flag to 0 on the next rising edge.
- R7: Each oscillator flag responds only to its own fault condition and its own clear strobe. `osc2_flag` does not depend on `osc1_hf_sel`.
- R8: The summary flag is set on the same edge as an oscillator flag. A summary clear has no effect while any oscillator flag or fault condition is still present.
- R9: The interrupt enable is loaded from `ie_wdata` only on an edge where `ie_wr` is 1. `nmi_req` is 1 exactly when the summary flag and the enable are both 1.
- R10: `fallback_active` rises on the same edge as the summary flag. It stays high through failed summary clears and falls on the same edge as a successful summary clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-up clear, asynchronous, active low |
| osc1_lf_fault_raw | input | 1 | Oscillator 1 stopped in low-frequency mode (asynchronous level) |
| osc1_hf_fault_raw | input | 1 | Oscillator 1 stopped in high-frequency mode (asynchronous level) |
| osc2_fault_raw | input | 1 | Oscillator 2 stopped (asynchronous level) |
| osc1_hf_sel | input | 1 | 1 selects the high-frequency mode of oscillator 1 |
| clr_osc1_flag | input | 1 | Clear request for the oscillator 1 flag |
| clr_osc2_flag | input | 1 | Clear request for the oscillator 2 flag |
| clr_summary | input | 1 | Clear request for the summary flag |
| ie_wr | input | 1 | Write strobe for the interrupt enable |
| ie_wdata | input | 1 | Value written to the interrupt enable |
| osc1_flag | output | 1 | Sticky fault flag of oscillator 1 |
| osc2_flag | output | 1 | Sticky fault flag of oscillator 2 |
| summary_flag | output | 1 | Summary oscillator fault flag |
| irq_enable | output | 1 | Current interrupt enable |
| nmi_req | output | 1 | Non-maskable interrupt request |
| fallback_active | output | 1 | Tells the clock multiplexers to use the safe source |

## Verification
The hardest state to reach is a failed summary clear after every raw fault has gone, because an oscillator flag is still set. To get there, the stimulus raises a fault, lets it go away, waits for the synchroniser to empty, and only then issues the summary clear. It then checks that both the summary flag and the fallback stay high. A second hard case is a clear strobe that lands on the same edge as the condition that sets the flag. The bench times this by counting the synchroniser stages. It places the clear exactly on the third edge after the raw fault.

// File: rtl/ofd_pkg.sv
package ofd_pkg;

  localparam int OSC_COUNT = 2;
  localparam int OSC1_IDX  = 0;
  localparam int OSC2_IDX  = 1;

  // Condition of the dual-mode oscillator: only the selected mode counts.
  function automatic logic ofd_mode_fault(input logic lf_fault,
                                          input logic hf_fault,
                                          input logic hf_sel);
    return hf_sel ? hf_fault : lf_fault;
  endfunction

  // Next state of a sticky flag: a present condition dominates a clear.
  function automatic logic ofd_sticky_next(input logic cur,
                                           input logic cond,
                                           input logic clr);
    return cond | (cur & ~clr);
  endfunction

endpackage

// File: rtl/ofd_sync.sv
module ofd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ofd_sticky_flag.sv
module ofd_sticky_flag
  import ofd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;

  assign flag_d = ofd_sticky_next(flag_q, cond_i, clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i |=> flag_q);

  assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && clr_i && !cond_i) |=> !flag_q);

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/ofd_summary.sv
module ofd_summary
  import ofd_pkg::*;
#(
  parameter int N = OSC_COUNT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] conds_i,
  input  logic         clr_i,
  input  logic         ie_wr_i,
  input  logic         ie_wdata_i,
  output logic         summary_o,
  output logic         ie_o,
  output logic         nmi_o,
  output logic         fallback_o
);

  logic summary_q;
  logic ie_q;
  logic fallback_q;
  logic fault_left;
  logic any_cond;
  logic clear_accept;

  assign any_cond     = |conds_i;
  assign fault_left   = (|flags_i) | any_cond;
  assign clear_accept = clr_i & ~fault_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      summary_q  <= 1'b0;
      fallback_q <= 1'b0;
      ie_q       <= 1'b0;
    end else begin
      summary_q  <= ofd_sticky_next(summary_q, fault_left, clr_i);
      fallback_q <= any_cond | (fallback_q & ~clear_accept);
      if (ie_wr_i) ie_q <= ie_wdata_i;
    end
  end

  assign summary_o  = summary_q;
  assign ie_o       = ie_q;
  assign fallback_o = fallback_q;
  assign nmi_o      = summary_q & ie_q;

  assert_summary_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags_i) |=> summary_q);

  assert_fallback_enter_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_cond |=> fallback_q);

  assert_fallback_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fallback_q) |-> ($past(clr_i) && !summary_q));

  assert_ie_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_wr_i |=> $stable(ie_q));

endmodule

// File: rtl/osc_fault_ctrl.sv
module osc_fault_ctrl
  import ofd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc1_lf_fault_raw,
  input  logic osc1_hf_fault_raw,
  input  logic osc2_fault_raw,
  input  logic osc1_hf_sel,
  input  logic clr_osc1_flag,
  input  logic clr_osc2_flag,
  input  logic clr_summary,
  input  logic ie_wr,
  input  logic ie_wdata,
  output logic osc1_flag,
  output logic osc2_flag,
  output logic summary_flag,
  output logic irq_enable,
  output logic nmi_req,
  output logic fallback_active
);

  localparam int RAW_W = OSC_COUNT + 1;

  logic [RAW_W-1:0]     raw_vec;
  logic [RAW_W-1:0]     sync_vec;
  logic [OSC_COUNT-1:0] osc_cond;
  logic [OSC_COUNT-1:0] osc_clr;
  logic [OSC_COUNT-1:0] osc_flag;

  assign raw_vec = {osc2_fault_raw, osc1_hf_fault_raw, osc1_lf_fault_raw};

  ofd_sync #(.WIDTH(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_vec),
    .sync_o  (sync_vec)
  );

  assign osc_cond[OSC1_IDX] = ofd_mode_fault(sync_vec[0], sync_vec[1], osc1_hf_sel);
  assign osc_cond[OSC2_IDX] = sync_vec[2];
  assign osc_clr[OSC1_IDX]  = clr_osc1_flag;
  assign osc_clr[OSC2_IDX]  = clr_osc2_flag;

  for (genvar g = 0; g < OSC_COUNT; g++) begin : g_flag
    ofd_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_i (osc_cond[g]),
      .clr_i  (osc_clr[g]),
      .flag_o (osc_flag[g])
    );
  end

  ofd_summary #(.N(OSC_COUNT)) u_summary (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags_i    (osc_flag),
    .conds_i    (osc_cond),
    .clr_i      (clr_summary),
    .ie_wr_i    (ie_wr),
    .ie_wdata_i (ie_wdata),
    .summary_o  (summary_flag),
    .ie_o       (irq_enable),
    .nmi_o      (nmi_req),
    .fallback_o (fallback_active)
  );

  assign osc1_flag = osc_flag[OSC1_IDX];
  assign osc2_flag = osc_flag[OSC2_IDX];

  assert_nmi_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (summary_flag && irq_enable));

  assert_nmi_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_enable |-> !nmi_req);

  assert_summary_covers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (osc1_flag || osc2_flag) |-> summary_flag);

  assert_fallback_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fallback_active |-> summary_flag);

  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!nmi_req && !fallback_active);
  end

endmodule

// File: tb/osc_fault_ctrl_test.sv
`timescale 1ns/1ps
module osc_fault_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lf = 1'b0, hf = 1'b0, f2 = 1'b0, sel = 1'b0;
  logic c1 = 1'b0, c2 = 1'b0, cs = 1'b0, iw = 1'b0, id = 1'b0;
  logic o1, o2, sm, ie, nmi, fb;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  osc_fault_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .osc1_lf_fault_raw(lf), .osc1_hf_fault_raw(hf), .osc2_fault_raw(f2),
    .osc1_hf_sel(sel), .clr_osc1_flag(c1), .clr_osc2_flag(c2),
    .clr_summary(cs), .ie_wr(iw), .ie_wdata(id),
    .osc1_flag(o1), .osc2_flag(o2), .summary_flag(sm),
    .irq_enable(ie), .nmi_req(nmi), .fallback_active(fb)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // which: 1 = osc1 clear, 2 = osc2 clear, 3 = summary clear
  task automatic strobe(input int which);
    c1 = (which == 1); c2 = (which == 2); cs = (which == 3);
    tick(1);
    c1 = 1'b0; c2 = 1'b0; cs = 1'b0;
  endtask

  task automatic write_ie(input logic v);
    iw = 1'b1; id = v;
    tick(1);
    iw = 1'b0; id = ~v;
  endtask

  task automatic clean_all();
    lf = 0; hf = 0; f2 = 0;
    tick(3);
    strobe(1); strobe(2); strobe(3);
  endtask

  task automatic t_reset();
    tick(2);
    check("R1 osc1_flag", o1, 0); check("R1 osc2_flag", o2, 0);
    check("R1 summary", sm, 0);   check("R1 enable", ie, 0);
    check("R1 nmi", nmi, 0);      check("R1 fallback", fb, 0);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_osc2_cycle();
    f2 = 1;
    tick(2);
    check("R2 not yet after 2 edges", o2, 0);
    tick(1);
    check("R2 flag after 3 edges", o2, 1);
    check("R8 summary with flag", sm, 1);
    check("R10 fallback with summary", fb, 1);
    check("R7 osc1 untouched", o1, 0);
    check("R9 nmi masked", nmi, 0);
    strobe(2);
    check("R5 clear during fault", o2, 1);
    strobe(1);
    check("R7 osc1 clear leaves osc2", o2, 1);
    f2 = 0;
    tick(3);
    check("R4 flag sticky after fault gone", o2, 1);
    strobe(3);
    check("R8 summary clear blocked by flag", sm, 1);
    check("R10 fallback held on failed clear", fb, 1);
    strobe(2);
    check("R6 clear with no fault", o2, 0);
    check("R8 summary still sticky", sm, 1);
    check("R10 fallback still up", fb, 1);
    strobe(3);
    check("R8 summary cleared", sm, 0);
    check("R10 fallback falls with summary", fb, 0);
  endtask

  task automatic t_set_wins();
    f2 = 1; tick(3);
    f2 = 0; tick(3);
    f2 = 1; tick(2);
    strobe(2);
    check("R5 set wins over same-edge clear", o2, 1);
    clean_all();
    check("R6 cleanup", o2, 0);
  endtask

  task automatic t_mode();
    sel = 0; hf = 1;
    tick(4);
    check("R3 hf fault ignored in lf mode", o1, 0);
    check("R3 no summary from unselected mode", sm, 0);
    lf = 1;
    tick(3);
    check("R3 lf fault counted in lf mode", o1, 1);
    clean_all();
    check("R3 cleanup", o1, 0);
    sel = 1; lf = 1;
    tick(4);
    check("R3 lf fault ignored in hf mode", o1, 0);
    hf = 1;
    tick(3);
    check("R3 hf fault counted in hf mode", o1, 1);
    f2 = 1;
    tick(3);
    check("R7 osc2 set in hf mode", o2, 1);
    clean_all();
    check("R3 cleanup hf", o1, 0);
    check("R7 cleanup osc2", o2, 0);
    sel = 0;
  endtask

  task automatic t_nmi();
    write_ie(1);
    check("R9 enable written", ie, 1);
    check("R9 no request without summary", nmi, 0);
    f2 = 1;
    tick(3);
    check("R9 request raised", nmi, 1);
    iw = 0; id = 0;
    tick(2);
    check("R9 enable kept without strobe", ie, 1);
    write_ie(0);
    check("R9 request masked", nmi, 0);
    write_ie(1);
    check("R9 request restored", nmi, 1);
    clean_all();
    check("R9 request gone after clear", nmi, 0);
  endtask

  initial begin
    t_reset();
    t_osc2_cycle();
    t_set_wins();
    t_mode();
    t_nmi();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule